// File: doc/BRIEF.md
# Predicated Vector Element Writeback

This block forms the value written back to a vector destination register when an operation runs under a predicate mask. It takes the freshly computed result vector and the current contents of the destination. It then builds the outgoing vector element by element. Each element is controlled by one bit of a predicate taken from a built-in file of eight mask registers. A mode bit picks what happens to elements whose predicate bit is clear. In zeroing mode they become zero. In merge mode they keep the old destination value, which gives the same result as a blend.

Predicate selector value 0 is special. When it is used as a predicate it means "no masking": every element takes the new result. The stored contents of mask register 0 are ignored for that purpose. For every other use, mask register 0 is an ordinary register. It is written through the mask write port and read through the mask read port like the other seven. A mask write in the same cycle as a predicated operation that names that register is forwarded, so the operation sees the new predicate.

The output side is a two-state machine. `ST_IDLE` means no result is presented. `ST_EMIT` means a result is presented with `out_valid` high. The transition IDLE→EMIT happens on a cycle with `in_valid` high. EMIT→EMIT happens on back-to-back valid inputs. EMIT→IDLE happens on a cycle with `in_valid` low. IDLE→IDLE happens while no input arrives.

Top module: `pred_vec_writeback`

## Requirements
- R1: The mask file holds eight 64-bit registers, indexed 0 to 7, all zero after reset. A write through `mwr_en`/`mwr_idx`/`mwr_data` is visible on `mrd_data` (combinational read at `mrd_idx`) from the cycle after the write edge.
- R2: Mask register 0 is stored and read back like any other register through the write and read ports.
- R3: With `pred_sel` = 0, the operation is unmasked in both modes: every `out_we` bit is 1 and `out_vec` equals the new result, whatever mask register 0 holds.
- R4: Element i occupies bits [32*i+31 : 32*i] of each vector and is governed by bit i of the selected mask. Only mask bits 15..0 are used; bits 63..16 have no effect.
- R5: In zeroing mode (`zero_mode` = 1), an element whose mask bit is 0 is output as zero, and all 16 `out_we` bits are 1.
- R6: In merge mode (`zero_mode` = 0), an element whose mask bit is 0 is output as the old destination element, and `out_we` equals the 16 selected mask bits.
- R7: An element whose mask bit is 1 is output as the new result element in either mode.
- R8: `out_vec`/`out_we` are registered and presented with `out_valid` high exactly one cycle after a cycle with `in_valid` high. `out_valid` is low one cycle after a cycle with `in_valid` low, and low after reset.
- R9: When a mask write targets register r (r ≠ 0) in the same cycle that a valid operation uses `pred_sel` = r, the operation uses the value being written.
- R10: A write to mask register 0 in the same cycle as an operation with `pred_sel` = 0 leaves that operation unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| zero_mode | input | 1 | 1 = zeroing, 0 = merge |
| pred_sel | input | 3 | Predicate mask register selector; 0 = unmasked |
| new_vec | input | 512 | Newly computed result vector |
| old_vec | input | 512 | Current destination vector |
| mwr_en | input | 1 | Mask register write enable |
| mwr_idx | input | 3 | Mask register written |
| mwr_data | input | 64 | Mask write value |
| mrd_idx | input | 3 | Mask register read index |
| mrd_data | output | 64 | Stored value of register `mrd_idx` |
| out_valid | output | 1 | Writeback outputs valid |
| out_vec | output | 512 | Vector to write back |
| out_we | output | 16 | Per-element write enables |

## Verification
A corrupted mask register appears on `mrd_data` the cycle after the write. It also shows up in the element pattern of the very next predicated result, one cycle after that result's `in_valid`. A missing forward path shows up as a result built from the stale predicate exactly one cycle after the colliding write. A stuck state machine shows up as `out_valid` disagreeing with the previous cycle's `in_valid`. Treating selector 0 as a real read shows up as cleared enables or merged elements whenever register 0 holds a non-all-ones value.

// File: rtl/wb_pkg.sv
package wb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } wb_state_e;
endpackage

// File: rtl/wb_mask_file.sv
module wb_mask_file #(
    parameter int NUM_MREG = 8,
    parameter int MASK_W   = 64,
    parameter int PRED_W   = 16,
    localparam int IDX_W   = $clog2(NUM_MREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [MASK_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [MASK_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  pr_idx,
    output logic [PRED_W-1:0] pr_data
);
    logic [MASK_W-1:0] regs_q [NUM_MREG];

    for (genvar r = 0; r < NUM_MREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[r] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(r))) begin
                regs_q[r] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = regs_q[rd_idx];
        pr_data = regs_q[pr_idx][PRED_W-1:0];
    end
endmodule

// File: rtl/wb_pred_select.sv
module wb_pred_select #(
    parameter int NUM_MREG = 8,
    parameter int PRED_W   = 16,
    localparam int IDX_W   = $clog2(NUM_MREG)
) (
    input  logic [IDX_W-1:0]  sel,
    input  logic [PRED_W-1:0] stored,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PRED_W-1:0] wr_low,
    output logic [PRED_W-1:0] pred
);
    logic fwd;

    always_comb begin
        fwd = wr_en && (wr_idx == sel);
        if (sel == '0) begin
            pred = '1;
        end else if (fwd) begin
            pred = wr_low;
        end else begin
            pred = stored;
        end
    end
endmodule

// File: rtl/wb_lane_merge.sv
module wb_lane_merge #(
    parameter int ELEM_W = 32
) (
    input  logic              keep,
    input  logic              zero_mode,
    input  logic [ELEM_W-1:0] new_elem,
    input  logic [ELEM_W-1:0] old_elem,
    output logic [ELEM_W-1:0] res_elem,
    output logic              res_we
);
    always_comb begin
        if (keep) begin
            res_elem = new_elem;
        end else if (zero_mode) begin
            res_elem = '0;
        end else begin
            res_elem = old_elem;
        end
        res_we = keep | zero_mode;
    end
endmodule

// File: rtl/pred_vec_writeback.sv
module pred_vec_writeback #(
    parameter int NUM_ELEM = 16,
    parameter int ELEM_W   = 32,
    parameter int NUM_MREG = 8,
    parameter int MASK_W   = 64,
    localparam int VEC_W   = NUM_ELEM * ELEM_W,
    localparam int IDX_W   = $clog2(NUM_MREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                zero_mode,
    input  logic [IDX_W-1:0]    pred_sel,
    input  logic [VEC_W-1:0]    new_vec,
    input  logic [VEC_W-1:0]    old_vec,
    input  logic                mwr_en,
    input  logic [IDX_W-1:0]    mwr_idx,
    input  logic [MASK_W-1:0]   mwr_data,
    input  logic [IDX_W-1:0]    mrd_idx,
    output logic [MASK_W-1:0]   mrd_data,
    output logic                out_valid,
    output logic [VEC_W-1:0]    out_vec,
    output logic [NUM_ELEM-1:0] out_we
);
    import wb_pkg::*;

    wb_state_e             state_q, state_nx;
    logic [NUM_ELEM-1:0]   stored_pred;
    logic [NUM_ELEM-1:0]   pred;
    logic [VEC_W-1:0]      vec_nx;
    logic [NUM_ELEM-1:0]   we_nx;

    wb_mask_file #(
        .NUM_MREG (NUM_MREG),
        .MASK_W   (MASK_W),
        .PRED_W   (NUM_ELEM)
    ) i_mfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mwr_en),
        .wr_idx  (mwr_idx),
        .wr_data (mwr_data),
        .rd_idx  (mrd_idx),
        .rd_data (mrd_data),
        .pr_idx  (pred_sel),
        .pr_data (stored_pred)
    );

    wb_pred_select #(
        .NUM_MREG (NUM_MREG),
        .PRED_W   (NUM_ELEM)
    ) i_psel (
        .sel    (pred_sel),
        .stored (stored_pred),
        .wr_en  (mwr_en),
        .wr_idx (mwr_idx),
        .wr_low (mwr_data[NUM_ELEM-1:0]),
        .pred   (pred)
    );

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_lane
        wb_lane_merge #(.ELEM_W(ELEM_W)) i_lane (
            .keep      (pred[e]),
            .zero_mode (zero_mode),
            .new_elem  (new_vec[e*ELEM_W +: ELEM_W]),
            .old_elem  (old_vec[e*ELEM_W +: ELEM_W]),
            .res_elem  (vec_nx[e*ELEM_W +: ELEM_W]),
            .res_we    (we_nx[e])
        );

        // R6: in merge mode an unwritten element carries the old value
        assert_merge_keeps_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !zero_mode) |=>
                (out_we[e] || (out_vec[e*ELEM_W +: ELEM_W] == $past(old_vec[e*ELEM_W +: ELEM_W]))));

        // R5/R7: in zeroing mode an element is either zero or the new value
        assert_zero_or_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && zero_mode) |=>
                ((out_vec[e*ELEM_W +: ELEM_W] == '0) ||
                 (out_vec[e*ELEM_W +: ELEM_W] == $past(new_vec[e*ELEM_W +: ELEM_W]))));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec <= '0;
            out_we  <= '0;
        end else if (in_valid) begin
            out_vec <= vec_nx;
            out_we  <= we_nx;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_quiet_after_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_unmasked_sel0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_sel == '0) |=> ((out_we == '1) && (out_vec == $past(new_vec))));

    assert_zero_all_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_mode) |=> (out_we == '1));

    assert_bypass_pred_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_mode && mwr_en && mwr_idx == pred_sel && pred_sel != '0)
            |=> (out_we == $past(mwr_data[NUM_ELEM-1:0])));
endmodule

// File: tb/test_pred_vec_writeback.sv
module test_pred_vec_writeback;
    localparam int NE = 16;
    localparam int EW = 32;
    localparam int VW = NE * EW;

    typedef struct {
        logic [VW-1:0] vec;
        logic [NE-1:0] we;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          zero_mode = 1'b0;
    logic [2:0]    pred_sel = '0;
    logic [VW-1:0] new_vec = '0;
    logic [VW-1:0] old_vec = '0;
    logic          mwr_en = 1'b0;
    logic [2:0]    mwr_idx = '0;
    logic [63:0]   mwr_data = '0;
    logic [2:0]    mrd_idx = '0;
    logic [63:0]   mrd_data;
    logic          out_valid;
    logic [VW-1:0] out_vec;
    logic [NE-1:0] out_we;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    logic [63:0] model [8];
    bit done = 1'b0;

    always #10 clk = ~clk;

    pred_vec_writeback i_pred_vec_writeback (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .zero_mode(zero_mode),
        .pred_sel(pred_sel), .new_vec(new_vec), .old_vec(old_vec),
        .mwr_en(mwr_en), .mwr_idx(mwr_idx), .mwr_data(mwr_data),
        .mrd_idx(mrd_idx), .mrd_data(mrd_data), .out_valid(out_valid),
        .out_vec(out_vec), .out_we(out_we)
    );

    function automatic logic [VW-1:0] mkvec(input logic [31:0] seed);
        logic [VW-1:0] v;
        for (int i = 0; i < NE; i++) v[i*EW +: EW] = seed ^ (32'h0101_0101 * (i + 1));
        return v;
    endfunction

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected out_valid: actual 1 expected 0");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (out_vec !== e.vec || out_we !== e.we) begin
                    errors++;
                    $display("FAIL %s: actual we=%h vec=%h expected we=%h vec=%h",
                             e.tag, out_we, out_vec, e.we, e.vec);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic mwrite(input logic [2:0] idx, input logic [63:0] d);
        @(negedge clk);
        in_valid = 1'b0;
        mwr_en = 1'b1; mwr_idx = idx; mwr_data = d;
        model[idx] = d;
        @(negedge clk);
        mwr_en = 1'b0;
    endtask

    task automatic mread(input logic [2:0] idx, input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        mrd_idx = idx;
        #1;
        check(mrd_data === model[idx], tag, mrd_data, model[idx]);
    endtask

    // Driver: one operation, optionally with a same-cycle mask write
    task automatic op(input logic [2:0] sel, input bit zm, input logic [31:0] s,
                      input bit wr, input logic [2:0] widx, input logic [63:0] wd,
                      input string tag);
        exp_t e;
        logic [NE-1:0] pb;
        logic [VW-1:0] nv, ov;
        @(negedge clk);
        nv = mkvec(s); ov = mkvec(~s);
        if (sel == 0) pb = '1;
        else if (wr && widx == sel) pb = wd[NE-1:0];
        else pb = model[sel][NE-1:0];
        for (int i = 0; i < NE; i++) begin
            e.we[i] = zm ? 1'b1 : pb[i];
            e.vec[i*EW +: EW] = pb[i] ? nv[i*EW +: EW] : (zm ? '0 : ov[i*EW +: EW]);
        end
        e.tag = tag;
        q.push_back(e);
        in_valid = 1'b1; zero_mode = zm; pred_sel = sel;
        new_vec = nv; old_vec = ov;
        mwr_en = wr; mwr_idx = widx; mwr_data = wd;
        if (wr) model[widx] = wd;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; mwr_en = 1'b0;
        end
    endtask

    initial begin
        for (int r = 0; r < 8; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid === 1'b0, "R8 reset out_valid", {63'd0, out_valid}, 64'd0);
        for (int r = 0; r < 8; r++) mread(3'(r), "R1 reset contents");

        // R2: register 0 is ordinary storage
        mwrite(3'd0, 64'h0000_0000_0000_1234);
        mread(3'd0, "R2 k0 readback");
        // R1: all registers
        for (int r = 1; r < 8; r++) mwrite(3'(r), 64'hDEAD_0000_0000_0000 | (64'h1111 * r));
        for (int r = 0; r < 8; r++) mread(3'(r), "R1 readback");

        // R3: selector 0 unmasked in both modes, k0 holds 0x1234
        op(3'd0, 1'b0, 32'h1000_0001, 1'b0, 3'd0, '0, "R3 sel0 merge");
        op(3'd0, 1'b1, 32'h1000_0002, 1'b0, 3'd0, '0, "R3 sel0 zero");
        idle(1);
        // R6/R7/R4: merge through k3, then R5 zeroing
        mwrite(3'd3, 64'h0000_0000_0000_A5C3);
        op(3'd3, 1'b0, 32'h2000_0003, 1'b0, 3'd0, '0, "R6 R7 merge k3");
        op(3'd3, 1'b1, 32'h2000_0004, 1'b0, 3'd0, '0, "R5 R7 zero k3");
        idle(1);
        // R4: upper mask bits ignored
        mwrite(3'd5, 64'hFFFF_FFFF_FFFF_0000 | 64'h00F0);
        op(3'd5, 1'b0, 32'h3000_0005, 1'b0, 3'd0, '0, "R4 upper bits merge");
        op(3'd5, 1'b1, 32'h3000_0006, 1'b0, 3'd0, '0, "R4 upper bits zero");
        // R6: all-zero predicate keeps everything
        mwrite(3'd6, 64'h0);
        op(3'd6, 1'b0, 32'h3000_0007, 1'b0, 3'd0, '0, "R6 empty predicate");
        // R9: same-cycle write forwarded
        op(3'd2, 1'b0, 32'h4000_0008, 1'b1, 3'd2, 64'h0000_0000_0000_0F0F, "R9 bypass merge");
        op(3'd2, 1'b0, 32'h4000_0009, 1'b0, 3'd0, '0, "R9 value kept after bypass");
        op(3'd7, 1'b1, 32'h4000_000A, 1'b1, 3'd4, 64'h0, "R9 other reg no forward");
        // R10: write k0 while sel0 in use
        op(3'd0, 1'b0, 32'h5000_000B, 1'b1, 3'd0, 64'h0, "R10 k0 write sel0");
        idle(1);
        mread(3'd0, "R10 R2 k0 written");
        // R8: out_valid low after a gap
        idle(2);
        check(out_valid === 1'b0, "R8 idle out_valid", {63'd0, out_valid}, 64'd0);
        idle(2);
        check(q.size() == 0, "R8 all results seen", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule